// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steers a multicycle processor datapath from a stored control program instead of from a hand-built state machine. A 4-bit micro-program counter selects one 18-bit control word. The packed fields of that word drive the ALU, operand-select, register-file, memory and program-counter control lines directly.

A 2-bit sequencing field in the same word picks the next micro-address. It can return to fetch at address 0, step to the next address, or branch several ways through one of two lookup tables that are indexed by the 6-bit instruction opcode. The control program covers loads, stores, register-register ALU operations, branch-if-equal and jump. Opcodes that the tables do not list lead back to fetch.

The surrounding datapath holds the opcode steady for the whole instruction. It reads the control lines in the same cycle that the micro-address is presented.

Top module: `uc_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is 0. After release, the first cycle presents the fetch word at address 0.
- R2: Address 0 (fetch) asserts mem_read, ir_write and pc_write, with alu_src_b=01, alu_op=00, alu_src_a=0 and pc_source=00. Its sequencing is increment, so the next address is 1.
- R3: Address 1 (decode) drives alu_src_b=11 and no write enables. It dispatches through table 1: opcode 0x23 or 0x2B goes to 2, 0x00 goes to 6, 0x04 goes to 8, and 0x02 goes to 9.
- R4: Address 2 drives alu_src_a=1 and alu_src_b=10. It dispatches through table 2: opcode 0x23 goes to 3 and 0x2B goes to 5.
- R5: A load (0x23) visits 0,1,2,3,4,0. Address 3 asserts mem_read and i_or_d. Address 4 asserts reg_write and mem_to_reg, with reg_dst=0.
- R6: A store (0x2B) visits 0,1,2,5,0. Address 5 asserts mem_write and i_or_d.
- R7: A register ALU operation (0x00) visits 0,1,6,7,0. Address 6 drives alu_op=10, alu_src_a=1 and alu_src_b=00. Address 7 asserts reg_write and reg_dst, with mem_to_reg=0.
- R8: A branch (0x04) visits 0,1,8,0. Address 8 drives alu_op=01, alu_src_a=1, pc_write_cond=1 and pc_source=01.
- R9: A jump (0x02) visits 0,1,9,0. Address 9 drives pc_write=1 and pc_source=10.
- R10: An opcode that a table does not list makes that dispatch go to address 0. This applies both at decode and at address 2.
- R11: mem_read and mem_write are never asserted together. ir_write is asserted only at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Instruction opcode used by the dispatch tables |
| upc | output | 4 | Current micro-address |
| alu_op | output | 2 | ALU operation class (00 add, 01 subtract, 10 by function field) |
| alu_src_a | output | 1 | First ALU operand: 0 program counter, 1 register A |
| alu_src_b | output | 2 | Second ALU operand: 00 B, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Write-back source: 1 memory data register |
| reg_dst | output | 1 | Destination field select: 1 rd |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| i_or_d | output | 1 | Memory address: 0 program counter, 1 ALU result register |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional program counter write |
| pc_write_cond | output | 1 | Program counter write when ALU zero |
| pc_source | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
The checker watches every cycle for the fixed successions of the control program. Fetch is followed by decode, 3 by 4 and 6 by 7, and the terminal addresses are followed by 0. A dispatch may only land on a legal target, and the memory read and write strobes never overlap. Which target a given opcode selects, the exact control word at each address, the complete per-class traces, a change of opcode between the two dispatches, and a reset in mid-instruction can only be shown by the bench's scenarios.

// File: rtl/uc_pkg.sv
package uc_pkg;

    localparam int OP_W  = 6;
    localparam int UA_W  = 4;
    localparam int DEPTH = 2 ** UA_W;

    localparam logic [OP_W-1:0] OP_ALU  = 6'h00;
    localparam logic [OP_W-1:0] OP_JMP  = 6'h02;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'h04;
    localparam logic [OP_W-1:0] OP_LOAD = 6'h23;
    localparam logic [OP_W-1:0] OP_STOR = 6'h2B;

    typedef enum logic [1:0] {
        SQ_FETCH = 2'b00,
        SQ_TBL1  = 2'b01,
        SQ_TBL2  = 2'b10,
        SQ_STEP  = 2'b11
    } seq_e;

    // 18-bit packed control word, most significant field first
    typedef struct packed {
        logic [1:0] alu_op;
        logic       src_a;
        logic [1:0] src_b;
        logic       reg_write;
        logic       mem_to_reg;
        logic       reg_dst;
        logic       mem_read;
        logic       mem_write;
        logic       i_or_d;
        logic       ir_write;
        logic       pc_write;
        logic       pc_write_cond;
        logic [1:0] pc_source;
        seq_e       seq;
    } uword_t;

    function automatic uword_t micro_word(input logic [UA_W-1:0] a);
        uword_t w;
        w = '0;
        w.seq = SQ_FETCH;
        case (a)
            4'd0: begin
                w.src_b = 2'b01; w.mem_read = 1'b1; w.ir_write = 1'b1;
                w.pc_write = 1'b1; w.seq = SQ_STEP;
            end
            4'd1: begin w.src_b = 2'b11; w.seq = SQ_TBL1; end
            4'd2: begin w.src_a = 1'b1; w.src_b = 2'b10; w.seq = SQ_TBL2; end
            4'd3: begin w.mem_read = 1'b1; w.i_or_d = 1'b1; w.seq = SQ_STEP; end
            4'd4: begin w.reg_write = 1'b1; w.mem_to_reg = 1'b1; end
            4'd5: begin w.mem_write = 1'b1; w.i_or_d = 1'b1; end
            4'd6: begin w.alu_op = 2'b10; w.src_a = 1'b1; w.seq = SQ_STEP; end
            4'd7: begin w.reg_write = 1'b1; w.reg_dst = 1'b1; end
            4'd8: begin
                w.alu_op = 2'b01; w.src_a = 1'b1; w.pc_write_cond = 1'b1;
                w.pc_source = 2'b01;
            end
            4'd9: begin w.pc_write = 1'b1; w.pc_source = 2'b10; end
            default: ;
        endcase
        return w;
    endfunction

    function automatic logic [UA_W-1:0] tbl1_entry(input logic [OP_W-1:0] op);
        case (op)
            OP_LOAD, OP_STOR: return 4'd2;
            OP_ALU:           return 4'd6;
            OP_BEQ:           return 4'd8;
            OP_JMP:           return 4'd9;
            default:          return 4'd0;
        endcase
    endfunction

    function automatic logic [UA_W-1:0] tbl2_entry(input logic [OP_W-1:0] op);
        case (op)
            OP_LOAD: return 4'd3;
            OP_STOR: return 4'd5;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/uc_store.sv
module uc_store
    import uc_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    uword_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = micro_word(UA_W'(g));
    end

    assign word = rom[addr];
endmodule

// File: rtl/uc_dispatch.sv
module uc_dispatch
    import uc_pkg::*;
#(
    parameter int TABLE_SEL = 1
) (
    input  logic [OP_W-1:0] op,
    output logic [UA_W-1:0] target
);
    localparam int ENTRIES = 2 ** OP_W;

    logic [UA_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        if (TABLE_SEL == 1) begin : g_t1
            assign tbl[g] = tbl1_entry(OP_W'(g));
        end else begin : g_t2
            assign tbl[g] = tbl2_entry(OP_W'(g));
        end
    end

    assign target = tbl[op];
endmodule

// File: rtl/uc_next.sv
module uc_next
    import uc_pkg::*;
(
    input  seq_e            seq,
    input  logic [UA_W-1:0] cur,
    input  logic [UA_W-1:0] tgt1,
    input  logic [UA_W-1:0] tgt2,
    output logic [UA_W-1:0] nxt
);
    always_comb begin
        case (seq)
            SQ_TBL1: nxt = tgt1;
            SQ_TBL2: nxt = tgt2;
            SQ_STEP: nxt = cur + UA_W'(1);
            default: nxt = '0;
        endcase
    end
endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
    import uc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] upc,
    output logic [1:0]      alu_op,
    output logic            alu_src_a,
    output logic [1:0]      alu_src_b,
    output logic            reg_write,
    output logic            mem_to_reg,
    output logic            reg_dst,
    output logic            mem_read,
    output logic            mem_write,
    output logic            i_or_d,
    output logic            ir_write,
    output logic            pc_write,
    output logic            pc_write_cond,
    output logic [1:0]      pc_source
);
    typedef struct packed {
        logic [UA_W-1:0] upc;
    } state_t;

    state_t st_d, st_q;
    uword_t word;
    logic [UA_W-1:0] tgt1, tgt2, nxt;

    uc_store u_store (.addr(st_q.upc), .word(word));

    uc_dispatch #(.TABLE_SEL(1)) u_tbl1 (.op(opcode), .target(tgt1));
    uc_dispatch #(.TABLE_SEL(2)) u_tbl2 (.op(opcode), .target(tgt2));

    uc_next u_next (
        .seq (word.seq),
        .cur (st_q.upc),
        .tgt1(tgt1),
        .tgt2(tgt2),
        .nxt (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upc           = st_q.upc;
    assign alu_op        = word.alu_op;
    assign alu_src_a     = word.src_a;
    assign alu_src_b     = word.src_b;
    assign reg_write     = word.reg_write;
    assign mem_to_reg    = word.mem_to_reg;
    assign reg_dst       = word.reg_dst;
    assign mem_read      = word.mem_read;
    assign mem_write     = word.mem_write;
    assign i_or_d        = word.i_or_d;
    assign ir_write      = word.ir_write;
    assign pc_write      = word.pc_write;
    assign pc_write_cond = word.pc_write_cond;
    assign pc_source     = word.pc_source;
endmodule

// File: rtl/uc_sequencer_chk.sv
module uc_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] upc,
    input logic       mem_read,
    input logic       mem_write,
    input logic       ir_write
);
    // R2: fetch always steps to decode
    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd0 |=> upc == 4'd1);

    // R3: decode lands only on a table-1 target or back on fetch
    a_r3_decode_targets: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd1 |=> (upc == 4'd0 || upc == 4'd2 || upc == 4'd6 ||
                         upc == 4'd8 || upc == 4'd9));

    // R4: second dispatch lands only on 3, 5 or fetch
    a_r4_tbl2_targets: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd2 |=> (upc == 4'd0 || upc == 4'd3 || upc == 4'd5));

    // R5: load memory step is followed by write-back
    a_r5_load_step: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd3 |=> upc == 4'd4);

    // R7: ALU execute step is followed by write-back
    a_r7_alu_step: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 4'd6 |=> upc == 4'd7);

    // R6, R8, R9: terminal words return to fetch
    a_r6_r8_r9_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 4'd4 || upc == 4'd5 || upc == 4'd7 || upc == 4'd8 || upc == 4'd9)
        |=> upc == 4'd0);

    // R11: read and write strobes exclusive
    a_r11_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_read, mem_write}));

    // R11: instruction register loads only during fetch
    a_r11_ir_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        ir_write |-> upc == 4'd0);
endmodule

bind uc_sequencer uc_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upc      (upc),
    .mem_read (mem_read),
    .mem_write(mem_write),
    .ir_write (ir_write)
);

// File: tb/tb_uc_sequencer.sv
module tb_uc_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic [3:0] upc;
    logic [1:0] alu_op, alu_src_b, pc_source;
    logic alu_src_a, reg_write, mem_to_reg, reg_dst, mem_read, mem_write;
    logic i_or_d, ir_write, pc_write, pc_write_cond;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uc_sequencer dut (.*);

    // {alu_op, src_a, src_b, reg_write, mem_to_reg, reg_dst,
    //  mem_read, mem_write, i_or_d, ir_write, pc_write, pc_write_cond, pc_source}
    function automatic logic [15:0] exp_ctrl(input logic [3:0] a);
        case (a)
            4'd0: return 16'b00_0_01_000_1001_1000;
            4'd1: return 16'b00_0_11_000_0000_0000;
            4'd2: return 16'b00_1_10_000_0000_0000;
            4'd3: return 16'b00_0_00_000_1010_0000;
            4'd4: return 16'b00_0_00_110_0000_0000;
            4'd5: return 16'b00_0_00_000_0110_0000;
            4'd6: return 16'b10_1_00_000_0000_0000;
            4'd7: return 16'b00_0_00_101_0000_0000;
            4'd8: return 16'b01_1_00_000_0000_0101;
            4'd9: return 16'b00_0_00_000_0000_1010;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] act_ctrl();
        return {alu_op, alu_src_a, alu_src_b, reg_write, mem_to_reg, reg_dst,
                mem_read, mem_write, i_or_d, ir_write, pc_write, pc_write_cond,
                pc_source};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    // {opcode, trace length, six 4-bit addresses (first in top nibble)}
    typedef struct packed {
        logic [5:0]  op;
        logic [3:0]  len;
        logic [23:0] trace;
        logic [39:0] tag;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{6'h23, 4'd6, 24'h012340, "R5 ld"},
        '{6'h2B, 4'd5, 24'h012500, "R6 st"},
        '{6'h00, 4'd5, 24'h016700, "R7 al"},
        '{6'h04, 4'd4, 24'h018000, "R8 bq"},
        '{6'h02, 4'd4, 24'h019000, "R9 jp"},
        '{6'h3F, 4'd3, 24'h010000, "R10 u"},
        '{6'h08, 4'd3, 24'h010000, "R10 v"}
    };

    initial begin
        #200_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #25;
        chk("R1 reset upc", {12'h0, upc}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 first word", act_ctrl(), exp_ctrl(4'd0));

        for (int v = 0; v < NV; v++) begin
            opcode = VECS[v].op;
            for (int k = 0; k < int'(VECS[v].len); k++) begin
                logic [3:0] ea;
                if (k > 0) tick();
                ea = VECS[v].trace[23 - 4*k -: 4];
                chk($sformatf("%s upc step %0d", VECS[v].tag, k), {12'h0, upc}, {12'h0, ea});
                chk($sformatf("%s ctrl@%0d (R2 R3 R4)", VECS[v].tag, ea), act_ctrl(), exp_ctrl(ea));
            end
        end

        // R10: opcode changed to an unlisted table-2 entry between dispatches
        opcode = 6'h23;
        tick();
        chk("R3 decode", {12'h0, upc}, 16'h1);
        tick();
        chk("R4 at 2", {12'h0, upc}, 16'h2);
        opcode = 6'h00;
        tick();
        chk("R10 table2 unlisted", {12'h0, upc}, 16'h0);

        // R11: no overlap of memory strobes across a store
        opcode = 6'h2B;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R11 strobes", {15'h0, mem_read & mem_write}, 16'h0);
        end

        // R1: reset in mid-instruction
        opcode = 6'h23;
        tick();
        tick();
        tick();
        chk("R5 reached 3", {12'h0, upc}, 16'h3);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", {12'h0, upc}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R2 after reset", {12'h0, upc}, 16'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule